// File: doc/BRIEF.md
# Three-Channel Note Envelope and Vibrato Sequencer

This block shapes notes on three tone channels of a programmable sound generator. A slow update strobe, typically near 50 Hz, drives it. A note is armed on a channel with a base tone period and a length counted in update strobes. On every strobe the block publishes, for each channel, an amplitude word and a tone period. The amplitude comes from a step table shared by all channels. The tone period is the base period shifted by a signed offset from a second shared step table.

Both step tables are indexed by time since the note began. A fresh note restarts both sequences from the beginning. The vibrato step counter of each channel advances before it is used and clears at a limit that differs per channel. Because of this, the three channels walk the offset table in different cycles, and only the third channel ever reaches offset entry 0. Software or a score player loads the tables through simple write ports and issues note-start strobes. The outputs feed the generator's amplitude and tone-period registers.

Top module: `noteSeqTop`

## Requirements
- R1: After reset every channel's amplitude word and tone period read 0, and both tables hold 0 in every entry.
- R2: Outputs change only in the cycle after `tick` is high; a note start or table write without a tick leaves them unchanged.
- R3: Amplitude word bit 4 (the generator's envelope-mode bit) is always 0. Bits 3..0 carry envelope entry k on the k-th tick of a note, counting from k = 0.
- R4: The envelope index saturates at entry 31 and holds there for the rest of the note.
- R5: A note start on a channel restarts that channel's envelope index at 0 and its vibrato counter at 0, even in the middle of a running note.
- R6: The tone period is the 12-bit base period plus the sign-extended 8-bit offset entry, clamped to 0 below and 4095 above.
- R7: The vibrato counter is incremented before use and its low 3 bits select the offset entry. It clears after reaching its limit, so channel 0 cycles entries 1..6, channel 1 cycles 1..7 and channel 2 cycles 1..7 then 0.
- R8: A note of length L plays on exactly L ticks. On later ticks the amplitude word is 0 and the tone period holds its last value.
- R9: A note start and a tick in the same cycle load the note first, and that tick outputs envelope entry 0 with offset entry 1.
- R10: A note start with length 0 plays nothing: ticks give amplitude 0 and leave the tone period unchanged.
- R11: A table write becomes visible to the first tick in a later cycle; a tick in the same cycle as the write still reads the old entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Update strobe, one step of every sequence |
| noteStart | input | 3 | Per-channel note-start strobe |
| notePeriod | input | 12 | Base tone period for the note being started |
| noteLen | input | 8 | Note length in ticks for the note being started |
| envWrEn | input | 1 | Envelope table write enable |
| envWrAddr | input | 5 | Envelope table entry |
| envWrData | input | 4 | Envelope level to store |
| vibWrEn | input | 1 | Offset table write enable |
| vibWrAddr | input | 3 | Offset table entry |
| vibWrData | input | 8 | Signed offset to store |
| chanAmp | output | 3x5 | Per-channel amplitude word, bit 4 mode, bits 3..0 level |
| chanPeriod | output | 3x12 | Per-channel tone period |

## Verification
The bench runs long notes past the 32nd tick. A design that let the envelope index wrap would fall back to entry 0 instead of holding entry 31. The three channels run side by side, so a wrong per-channel limit, or a counter used before its increment, shows up as a period offset from the wrong table entry on one channel. Restarts mid-note, zero-length notes, start-with-tick cycles and writes that coincide with a tick are all exercised. Each catches, respectively, a design that keeps old indices, plays a silent note, outputs entry 1 on the first tick, or forwards new table data a cycle early. Bases near 0 and 4095 with large offsets expose a sum that wraps instead of clamping.

// File: rtl/noteSeqPkg.sv
package noteSeqPkg;
  localparam int NUM_CH        = 3;
  localparam int ENV_DEPTH     = 32;
  localparam int VIB_DEPTH     = 8;
  localparam int PER_W         = 12;
  localparam int AMP_W         = 4;
  localparam int LEN_W         = 8;
  localparam int VIB_W         = 8;
  localparam int VIB_LIM_FIRST = 6;
  localparam int ENV_AW        = $clog2(ENV_DEPTH);
  localparam int VIB_AW        = $clog2(VIB_DEPTH);
  localparam int VC_W          = VIB_AW + 1;
  localparam int SUM_W         = PER_W + 2;

  typedef struct packed {
    logic [NUM_CH-1:0] loadNote;
    logic [NUM_CH-1:0] playStep;
    logic [NUM_CH-1:0] muteStep;
  } seqStrobes_t;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import noteSeqPkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              tick,
  input  logic [NUM_CH-1:0]                 noteStart,
  input  logic [LEN_W-1:0]                  noteLen,
  output seqStrobes_t                       strb,
  output logic [NUM_CH-1:0][ENV_AW-1:0]     envSel,
  output logic [NUM_CH-1:0][VIB_AW-1:0]     vibSel
);
  logic [NUM_CH-1:0] playV;
  logic [NUM_CH-1:0] muteV;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int LIMIT = VIB_LIM_FIRST + c;
      logic [LEN_W-1:0]  remain, remainEff;
      logic [ENV_AW-1:0] envIdx, envEff;
      logic [VC_W-1:0]   vibCnt, vibEff, vibNext;
      logic              playing;

      // a start in this cycle is applied before any tick in the same cycle
      always_comb begin
        remainEff = noteStart[c] ? noteLen : remain;
        envEff    = noteStart[c] ? '0 : envIdx;
        vibEff    = noteStart[c] ? '0 : vibCnt;
        vibNext   = vibEff + 1'b1;
        playing   = (remainEff != '0);
      end

      assign playV[c]  = tick & playing;
      assign muteV[c]  = tick & ~playing;
      assign envSel[c] = envEff;
      assign vibSel[c] = vibNext[VIB_AW-1:0];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          remain <= '0;
          envIdx <= '0;
          vibCnt <= '0;
        end else if (tick && playing) begin
          remain <= remainEff - 1'b1;
          envIdx <= (envEff == ENV_AW'(ENV_DEPTH - 1)) ? envEff : envEff + 1'b1;
          vibCnt <= (vibNext == VC_W'(LIMIT)) ? '0 : vibNext;
        end else if (noteStart[c]) begin
          remain <= noteLen;
          envIdx <= '0;
          vibCnt <= '0;
        end
      end
    end
  endgenerate

  assign strb.loadNote = noteStart;
  assign strb.playStep = playV;
  assign strb.muteStep = muteV;
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import noteSeqPkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  seqStrobes_t                       strb,
  input  logic [NUM_CH-1:0][ENV_AW-1:0]     envSel,
  input  logic [NUM_CH-1:0][VIB_AW-1:0]     vibSel,
  input  logic [PER_W-1:0]                  notePeriod,
  input  logic                              envWrEn,
  input  logic [ENV_AW-1:0]                 envWrAddr,
  input  logic [AMP_W-1:0]                  envWrData,
  input  logic                              vibWrEn,
  input  logic [VIB_AW-1:0]                 vibWrAddr,
  input  logic [VIB_W-1:0]                  vibWrData,
  output logic [NUM_CH-1:0][AMP_W:0]        chanAmp,
  output logic [NUM_CH-1:0][PER_W-1:0]      chanPeriod
);
  logic [AMP_W-1:0]        envTab [ENV_DEPTH];
  logic [VIB_W-1:0]        vibTab [VIB_DEPTH];
  logic [PER_W-1:0]        basePer [NUM_CH];
  logic [PER_W-1:0]        baseEff [NUM_CH];
  logic [VIB_W-1:0]        offRaw  [NUM_CH];
  logic signed [SUM_W-1:0] sumV    [NUM_CH];
  logic [PER_W-1:0]        satPer  [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENV_DEPTH; i++) envTab[i] <= '0;
      for (int i = 0; i < VIB_DEPTH; i++) vibTab[i] <= '0;
    end else begin
      if (envWrEn) envTab[envWrAddr] <= envWrData;
      if (vibWrEn) vibTab[vibWrAddr] <= vibWrData;
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      baseEff[c] = strb.loadNote[c] ? notePeriod : basePer[c];
      offRaw[c]  = vibTab[vibSel[c]];
      sumV[c]    = $signed({2'b00, baseEff[c]})
                 + $signed({{(SUM_W-VIB_W){offRaw[c][VIB_W-1]}}, offRaw[c]});
      if (sumV[c][SUM_W-1])      satPer[c] = '0;
      else if (sumV[c][PER_W])   satPer[c] = '1;
      else                       satPer[c] = sumV[c][PER_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (!rstN) begin
        basePer[c]    <= '0;
        chanAmp[c]    <= '0;
        chanPeriod[c] <= '0;
      end else begin
        if (strb.loadNote[c]) basePer[c] <= notePeriod;
        if (strb.playStep[c]) begin
          chanAmp[c]    <= {1'b0, envTab[envSel[c]]};
          chanPeriod[c] <= satPer[c];
        end else if (strb.muteStep[c]) begin
          chanAmp[c]    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/noteSeqTop.sv
module noteSeqTop
  import noteSeqPkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              tick,
  input  logic [NUM_CH-1:0]                 noteStart,
  input  logic [PER_W-1:0]                  notePeriod,
  input  logic [LEN_W-1:0]                  noteLen,
  input  logic                              envWrEn,
  input  logic [ENV_AW-1:0]                 envWrAddr,
  input  logic [AMP_W-1:0]                  envWrData,
  input  logic                              vibWrEn,
  input  logic [VIB_AW-1:0]                 vibWrAddr,
  input  logic [VIB_W-1:0]                  vibWrData,
  output logic [NUM_CH-1:0][AMP_W:0]        chanAmp,
  output logic [NUM_CH-1:0][PER_W-1:0]      chanPeriod
);
  seqStrobes_t                   strb;
  logic [NUM_CH-1:0][ENV_AW-1:0] envSel;
  logic [NUM_CH-1:0][VIB_AW-1:0] vibSel;

  seqCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .noteStart(noteStart),
    .noteLen(noteLen), .strb(strb), .envSel(envSel), .vibSel(vibSel)
  );

  seqDatapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .envSel(envSel), .vibSel(vibSel),
    .notePeriod(notePeriod),
    .envWrEn(envWrEn), .envWrAddr(envWrAddr), .envWrData(envWrData),
    .vibWrEn(vibWrEn), .vibWrAddr(vibWrAddr), .vibWrData(vibWrData),
    .chanAmp(chanAmp), .chanPeriod(chanPeriod)
  );
endmodule

// File: rtl/seqChecker.sv
module seqChecker
  import noteSeqPkg::*;
(
  input logic                              clk,
  input logic                              rstN,
  input logic                              tick,
  input logic [NUM_CH-1:0]                 noteStart,
  input logic [NUM_CH-1:0][AMP_W:0]        chanAmp,
  input logic [NUM_CH-1:0][PER_W-1:0]      chanPeriod,
  input seqStrobes_t                       strb,
  input logic [NUM_CH-1:0][ENV_AW-1:0]     envSel,
  input logic [NUM_CH-1:0][VIB_AW-1:0]     vibSel
);
  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(chanAmp) && $stable(chanPeriod)));

  assert_chan0_skips_edges_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.playStep[0] |-> (vibSel[0] != '0 && vibSel[0] != VIB_AW'(VIB_DEPTH - 1)));

  assert_chan1_skips_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.playStep[1] |-> (vibSel[1] != '0));

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_chk
      assert_mode_bit_low_R3: assert property (@(posedge clk) disable iff (!rstN)
        chanAmp[c][AMP_W] == 1'b0);

      assert_start_restarts_R5: assert property (@(posedge clk) disable iff (!rstN)
        noteStart[c] |-> (envSel[c] == '0 && vibSel[c] == VIB_AW'(1)));

      assert_mute_after_end_R8: assert property (@(posedge clk) disable iff (!rstN)
        strb.muteStep[c] |=> (chanAmp[c] == '0));
    end
  endgenerate
endmodule

bind noteSeqTop seqChecker u_seqChecker (
  .clk(clk), .rstN(rstN), .tick(tick), .noteStart(noteStart),
  .chanAmp(chanAmp), .chanPeriod(chanPeriod),
  .strb(strb), .envSel(envSel), .vibSel(vibSel)
);

// File: tb/test_noteSeqTop.sv
`timescale 1ns/1ps
module test_noteSeqTop;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tick = 1'b0;
  logic [2:0]        noteStart = '0;
  logic [11:0]       notePeriod = '0;
  logic [7:0]        noteLen = '0;
  logic              envWrEn = 1'b0;
  logic [4:0]        envWrAddr = '0;
  logic [3:0]        envWrData = '0;
  logic              vibWrEn = 1'b0;
  logic [2:0]        vibWrAddr = '0;
  logic [7:0]        vibWrData = '0;
  logic [2:0][4:0]   chanAmp;
  logic [2:0][11:0]  chanPeriod;

  noteSeqTop i_noteSeqTop (
    .clk(clk), .rstN(rstN), .tick(tick), .noteStart(noteStart),
    .notePeriod(notePeriod), .noteLen(noteLen),
    .envWrEn(envWrEn), .envWrAddr(envWrAddr), .envWrData(envWrData),
    .vibWrEn(vibWrEn), .vibWrAddr(vibWrAddr), .vibWrData(vibWrData),
    .chanAmp(chanAmp), .chanPeriod(chanPeriod)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  string curReq = "R1";

  // reference model state
  int envM [32];
  int vibM [8];
  int baseM [3];
  int remM [3];
  int eIdxM [3];
  int vCntM [3];
  int ampM [3];
  int perM [3];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) envM[i] = 0;
      for (int i = 0; i < 8; i++) vibM[i] = 0;
      for (int c = 0; c < 3; c++) begin
        baseM[c] = 0; remM[c] = 0; eIdxM[c] = 0; vCntM[c] = 0;
        ampM[c] = 0; perM[c] = 0;
      end
    end else begin
      for (int c = 0; c < 3; c++) begin
        if (noteStart[c]) begin
          baseM[c] = notePeriod; remM[c] = noteLen; eIdxM[c] = 0; vCntM[c] = 0;
        end
        if (tick) begin
          if (remM[c] > 0) begin
            int vn;
            int p;
            vn = vCntM[c] + 1;
            ampM[c] = envM[eIdxM[c]];
            p = baseM[c] + vibM[vn % 8];
            if (p < 0) p = 0;
            if (p > 4095) p = 4095;
            perM[c] = p;
            if (eIdxM[c] < 31) eIdxM[c] = eIdxM[c] + 1;
            vCntM[c] = (vn == 6 + c) ? 0 : vn;
            remM[c] = remM[c] - 1;
          end else begin
            ampM[c] = 0;
          end
        end
      end
      if (envWrEn) envM[envWrAddr] = envWrData;
      if (vibWrEn) vibM[vibWrAddr] = (vibWrData > 127) ? int'(vibWrData) - 256 : int'(vibWrData);
    end
  end

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare every cycle against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < 3; c++) begin
        checkVal(curReq, $sformatf("ch%0d amp", c), int'(chanAmp[c]), ampM[c]);
        checkVal(curReq, $sformatf("ch%0d period", c), int'(chanPeriod[c]), perM[c]);
      end
    end
  end

  task automatic cyc(input logic t, input logic [2:0] s, input int p, input int l);
    @(negedge clk);
    tick = t; noteStart = s; notePeriod = 12'(p); noteLen = 8'(l);
    envWrEn = 1'b0; vibWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'b000, 0, 0);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 3'b000, 0, 0);
      idle(gap);
    end
  endtask

  task automatic wrEnv(input int a, input int d, input logic t);
    @(negedge clk);
    tick = t; noteStart = '0; vibWrEn = 1'b0;
    envWrEn = 1'b1; envWrAddr = 5'(a); envWrData = 4'(d);
  endtask

  task automatic wrVib(input int a, input int d);
    @(negedge clk);
    tick = 1'b0; noteStart = '0; envWrEn = 1'b0;
    vibWrEn = 1'b1; vibWrAddr = 3'(a); vibWrData = 8'(d);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vals [8];
    vals = '{-9, 20, -30, 40, -50, 60, -70, 80};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset clears all outputs
    curReq = "R1";
    for (int c = 0; c < 3; c++) begin
      checkVal("R1", $sformatf("reset ch%0d amp", c), int'(chanAmp[c]), 0);
      checkVal("R1", $sformatf("reset ch%0d period", c), int'(chanPeriod[c]), 0);
    end

    // R11: fill tables, distinct levels and signed offsets
    curReq = "R11";
    for (int i = 0; i < 32; i++) wrEnv(i, (i * 5 + 1) % 16, 1'b0);
    for (int i = 0; i < 8; i++) wrVib(i, vals[i]);

    // R2: starts without a tick leave outputs untouched
    curReq = "R2";
    cyc(1'b0, 3'b001, 1000, 40);
    cyc(1'b0, 3'b010, 2000, 40);
    cyc(1'b0, 3'b100, 3000, 40);
    idle(3);
    for (int c = 0; c < 3; c++)
      checkVal("R2", $sformatf("no tick ch%0d amp", c), int'(chanAmp[c]), 0);

    // R3 R7 R4 R8: long notes on all channels, ticks spaced out
    for (int k = 0; k < 44; k++) begin
      if (k < 8)       curReq = "R3";
      else if (k < 32) curReq = "R7";
      else if (k < 40) curReq = "R4";
      else             curReq = "R8";
      ticks(1, 2);
    end
    checkVal("R8", "ch0 amp after end", int'(chanAmp[0]), 0);

    // R9: start with tick in the same cycle
    curReq = "R9";
    cyc(1'b1, 3'b111, 500, 5);
    idle(1);
    checkVal("R9", "ch0 amp first tick", int'(chanAmp[0]), 1);
    checkVal("R9", "ch1 period first tick", int'(chanPeriod[1]), 520);
    ticks(6, 0);

    // R5: restart mid-note, with and without a tick
    curReq = "R5";
    cyc(1'b1, 3'b001, 800, 20);
    ticks(3, 0);
    cyc(1'b1, 3'b001, 900, 20);
    ticks(2, 1);
    cyc(1'b0, 3'b010, 700, 9);
    ticks(4, 0);

    // R6: clamp at both ends
    curReq = "R6";
    cyc(1'b1, 3'b001, 4085, 3);
    idle(1);
    checkVal("R6", "ch0 high clamp", int'(chanPeriod[0]), 4095);
    cyc(1'b1, 3'b010, 10, 3);
    idle(1);
    cyc(1'b1, 3'b000, 0, 0);
    idle(1);
    checkVal("R6", "ch1 low clamp", int'(chanPeriod[1]), 0);
    ticks(3, 0);

    // R10: zero-length note is silent and keeps the period
    curReq = "R10";
    cyc(1'b1, 3'b100, 700, 0);
    ticks(3, 0);

    // R11: writes during a note, including a write on a tick cycle
    curReq = "R11";
    cyc(1'b1, 3'b001, 1200, 10);
    wrEnv(1, 15, 1'b0);
    ticks(1, 0);
    wrEnv(2, 0, 1'b1);
    wrEnv(3, 9, 1'b1);
    ticks(3, 0);
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule